// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Control

This block is the transmit half of an asynchronous serial port. A host pushes bytes through a write port into an eight-entry queue. The transmitter sends each byte on a single output line as a low start bit, eight data bits with the least significant bit first, and a high stop bit. The timing of every bit comes from a one-cycle baud tick supplied from outside. Each bit spans sixteen of these ticks.

A command port accepts a transmitter-control field and a four-bit action code. Through it the host can enable or disable the transmitter, reset it, and begin or end a break condition. During a break the line is held low for as long as the host wants. A break request does not cut into the data stream. It takes effect only once every byte already queued, or queued later, has left the shifter. Ending a break returns the line to the idle high level at once. The line then stays high for at least one full bit period before the next byte starts.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset `txd` is 1, `fifo_empty` is 1, `tx_empty` is 1, `overrun` is 0 and the transmitter is disabled.
- R2: Each byte is sent as a low start bit, eight data bits least significant bit first, then a high stop bit. Each bit lasts 16 `baud_tick` pulses, and bytes leave in the order they were written.
- R3: The field `cmd_tx` is 01 for enable, 10 for disable and 00 for no change. While the transmitter is disabled no new byte starts and written bytes stay queued. Enabling it later sends them.
- R4: Action code `cmd_misc`=0110 (start break) issued while enabled, with the queue and shifter empty, drives `txd` low within two bit times. `txd` stays low until a stop-break command arrives.
- R5: A start-break command waits for the byte in flight, for all queued bytes and for any bytes written after the command, including one written in the same cycle. The line goes low only after all of them are sent.
- R6: A start-break command issued while the transmitter is disabled is ignored.
- R7: Action code 0111 (stop break) makes `txd` high on the next cycle. `txd` then stays high for at least 16 baud ticks before the next start bit.
- R8: A command write that pairs `cmd_tx`=01 with action 0011 (reset) is ignored entirely, and so is a write with `cmd_tx`=11.
- R9: Action 0011 (reset transmitter) empties the queue and aborts the byte in flight and any pending break. It disables the transmitter and makes `txd` high on the next cycle. A byte written in that same cycle is dropped.
- R10: The queue holds 8 bytes. A write to a full queue is dropped, and `overrun` is high for exactly the next cycle.
- R11: `fifo_empty` is 1 exactly when no byte is queued. `tx_empty` is 1 only when no byte is queued and the shifter is idle, and it stays 0 while a byte is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse, 16 per serial bit |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| cmd_valid | input | 1 | Command write strobe |
| cmd_tx | input | 2 | Transmitter control: 00 none, 01 enable, 10 disable, 11 illegal |
| cmd_misc | input | 4 | Action: 0011 reset, 0110 start break, 0111 stop break, others none |
| txd | output | 1 | Serial output, idle high |
| fifo_empty | output | 1 | No byte queued |
| tx_empty | output | 1 | Queue empty and shifter idle |
| overrun | output | 1 | One-cycle pulse after a write was dropped because the queue was full |

## Verification
Two functions can fall in the same cycle: a start-break command and a byte write. The same holds for a reset command and a byte write. The bench drives both signals in one cycle. In the first case the scoreboard must see the new byte on the line before the break token. In the second case the queue must read empty afterwards, and no byte may ever appear once the transmitter is enabled again. A further collision covers a stop-break command while a byte is queued behind the break. There the bench counts the high cycles between the end of the break and the next start bit.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
    localparam int unsigned FRAME_BITS = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_BREAK = 2'd2,
        ST_MARK  = 2'd3
    } tx_state_e;

    localparam logic [1:0] TXC_NONE    = 2'b00;
    localparam logic [1:0] TXC_ENABLE  = 2'b01;
    localparam logic [1:0] TXC_DISABLE = 2'b10;
    localparam logic [1:0] TXC_ILLEGAL = 2'b11;

    localparam logic [3:0] ACT_RESET   = 4'b0011;
    localparam logic [3:0] ACT_BRK_ON  = 4'b0110;
    localparam logic [3:0] ACT_BRK_OFF = 4'b0111;
endpackage

// File: rtl/uart_brk_fifo.sv
module uart_brk_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty = (ptr_q.cnt == '0);
    assign full  = (ptr_q.cnt == CW'(DEPTH));
    assign head  = mem_q[ptr_q.rd];
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        ptr_d = ptr_q;
        mem_d = mem_q;
        if (push_ok) begin
            mem_d[ptr_q.wr] = push_data;
            ptr_d.wr = (ptr_q.wr == PTR_LAST) ? '0 : ptr_q.wr + 1'b1;
        end
        if (pop_ok) begin
            ptr_d.rd = (ptr_q.rd == PTR_LAST) ? '0 : ptr_q.rd + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
        if (clr) begin
            ptr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end
endmodule

// File: rtl/uart_brk_cmd.sv
module uart_brk_cmd
    import uart_brk_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_tx,
    input  logic [3:0] cmd_misc,
    output logic       do_enable,
    output logic       do_disable,
    output logic       do_reset,
    output logic       do_brk_on,
    output logic       do_brk_off
);
    logic legal;
    logic take;

    assign legal = (cmd_tx != TXC_ILLEGAL) &&
                   !((cmd_tx == TXC_ENABLE) && (cmd_misc == ACT_RESET));
    assign take  = cmd_valid && legal;

    assign do_enable  = take && (cmd_tx == TXC_ENABLE);
    assign do_disable = take && (cmd_tx == TXC_DISABLE);
    assign do_reset   = take && (cmd_misc == ACT_RESET);
    assign do_brk_on  = take && (cmd_misc == ACT_BRK_ON);
    assign do_brk_off = take && (cmd_misc == ACT_BRK_OFF);
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned FIFO_DEPTH    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_tx,
    input  logic [3:0] cmd_misc,
    output logic       txd,
    output logic       fifo_empty,
    output logic       tx_empty,
    output logic       overrun
);
    localparam int unsigned TW = $clog2(TICKS_PER_BIT);
    localparam int unsigned BW = $clog2(FRAME_BITS);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_BIT - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);

    typedef struct packed {
        tx_state_e             st;
        logic                  en;
        logic                  pend;
        logic [FRAME_BITS-1:0] sh;
        logic [BW-1:0]         bitn;
        logic [TW-1:0]         tick;
        logic                  ovr;
    } regs_t;

    localparam regs_t REGS_RST = '{st: ST_IDLE, en: 1'b0, pend: 1'b0, sh: '1,
                                   bitn: '0, tick: '0, ovr: 1'b0};

    regs_t d, q;

    logic c_en, c_dis, c_rst, c_brk_on, c_brk_off;
    logic f_empty, f_full, f_pop, f_push;
    logic [7:0] f_head;
    logic bit_end;

    uart_brk_cmd u_cmd (
        .cmd_valid  (cmd_valid),
        .cmd_tx     (cmd_tx),
        .cmd_misc   (cmd_misc),
        .do_enable  (c_en),
        .do_disable (c_dis),
        .do_reset   (c_rst),
        .do_brk_on  (c_brk_on),
        .do_brk_off (c_brk_off)
    );

    assign f_push = wr_en && !c_rst;

    uart_brk_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (8)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (c_rst),
        .push      (f_push),
        .push_data (wr_data),
        .pop       (f_pop),
        .head      (f_head),
        .empty     (f_empty),
        .full      (f_full)
    );

    assign bit_end = baud_tick && (q.tick == TICK_LAST);

    always_comb begin
        d     = q;
        d.ovr = 1'b0;
        f_pop = 1'b0;

        if (baud_tick) begin
            d.tick = bit_end ? '0 : q.tick + 1'b1;
        end
        if (c_en) begin
            d.en = 1'b1;
        end
        if (c_dis) begin
            d.en = 1'b0;
        end
        if (c_brk_on && q.en && (q.st != ST_BREAK)) begin
            d.pend = 1'b1;
        end

        unique case (q.st)
            ST_IDLE: begin
                d.tick = '0;
                if (q.en && !f_empty) begin
                    d.st   = ST_SHIFT;
                    d.sh   = {1'b1, f_head, 1'b0};
                    d.bitn = '0;
                    f_pop  = 1'b1;
                end else if (q.pend && f_empty && !c_brk_off) begin
                    d.st   = ST_BREAK;
                    d.pend = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (bit_end) begin
                    d.sh = {1'b1, q.sh[FRAME_BITS-1:1]};
                    if (q.bitn == BIT_LAST) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                    end
                end
            end
            ST_BREAK: begin
                d.tick = '0;
                if (c_brk_off) begin
                    d.st = ST_MARK;
                end
            end
            ST_MARK: begin
                if (bit_end) begin
                    d.st = ST_IDLE;
                end
            end
        endcase

        if (c_brk_off) begin
            d.pend = 1'b0;
        end
        if (wr_en && f_full) begin
            d.ovr = 1'b1;
        end
        if (c_rst) begin
            d     = REGS_RST;
            f_pop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end

    assign txd        = (q.st == ST_SHIFT) ? q.sh[0] : (q.st != ST_BREAK);
    assign fifo_empty = f_empty;
    assign tx_empty   = (q.st == ST_IDLE) && f_empty;
    assign overrun    = q.ovr;
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk
    import uart_brk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_tx,
    input logic [3:0] cmd_misc,
    input logic       wr_en,
    input logic       txd,
    input logic       fifo_empty,
    input logic       tx_empty,
    input logic       overrun,
    input tx_state_e  st,
    input logic       en,
    input logic       fifo_full
);
    AST_RESET_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_misc == ACT_RESET && cmd_tx != TXC_ENABLE && cmd_tx != TXC_ILLEGAL)
        |=> (txd && fifo_empty && tx_empty && !en)); // R9

    AST_CONFLICT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_tx == TXC_ENABLE && cmd_misc == ACT_RESET)
        |=> (en == $past(en))); // R8

    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_tx == TXC_ILLEGAL) |=> (en == $past(en))); // R8

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(wr_en && fifo_full)); // R10

    AST_BREAK_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BREAK && $past(st) != ST_BREAK)
        |-> ($past(st) == ST_IDLE && $past(fifo_empty))); // R5

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !en) |=> (st != ST_SHIFT)); // R3

    AST_STOP_BREAK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BREAK && cmd_valid && cmd_misc == ACT_BRK_OFF && cmd_tx != TXC_ILLEGAL)
        |=> txd); // R7

    AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> fifo_empty); // R11
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_tx     (cmd_tx),
    .cmd_misc   (cmd_misc),
    .wr_en      (wr_en),
    .txd        (txd),
    .fifo_empty (fifo_empty),
    .tx_empty   (tx_empty),
    .overrun    (overrun),
    .st         (q.st),
    .en         (q.en),
    .fifo_full  (f_full)
);

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;
    localparam int BIT_CLKS = 64;          // 16 ticks x 4 clocks
    localparam logic [8:0] BRK_TOKEN = 9'h100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_tx = 2'b00;
    logic [3:0] cmd_misc = 4'b0000;
    logic       txd, fifo_empty, tx_empty, overrun;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit mon_on = 1'b1;
    logic [8:0] sb [$];

    always #5 clk = ~clk;

    uart_brk_tx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cmd_valid  (cmd_valid),
        .cmd_tx     (cmd_tx),
        .cmd_misc   (cmd_misc),
        .txd        (txd),
        .fifo_empty (fifo_empty),
        .tx_empty   (tx_empty),
        .overrun    (overrun)
    );

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            baud_tick = (tc == 3);
            tc = (tc + 1) % 4;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                finish_run();
            end
        end
    end

    task automatic idle_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit expect_out);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        if (expect_out) sb.push_back({1'b0, b});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_cmd(input logic [1:0] t, input logic [3:0] m);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_tx = t;
        cmd_misc = m;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_tx = 2'b00;
        cmd_misc = 4'b0000;
    endtask

    task automatic put_both(input logic [1:0] t, input logic [3:0] m, input logic [7:0] b,
                            input bit expect_out);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_tx = t;
        cmd_misc = m;
        wr_en = 1'b1;
        wr_data = b;
        if (expect_out) sb.push_back({1'b0, b});
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_tx = 2'b00;
        cmd_misc = 4'b0000;
        wr_en = 1'b0;
    endtask

    task automatic wait_drain();
        while (sb.size() != 0) @(negedge clk);
        while (!tx_empty) @(negedge clk);
        idle_clks(4);
    endtask

    // Monitor: decodes frames on txd and compares against the scoreboard.
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_on && prev && !txd) begin
                logic [7:0] b;
                logic st_bit, sp_bit;
                logic [8:0] got, exp;
                idle_clks(BIT_CLKS / 2 - 1);
                st_bit = txd;
                for (int i = 0; i < 8; i++) begin
                    idle_clks(BIT_CLKS);
                    b[i] = txd;
                end
                idle_clks(BIT_CLKS);
                sp_bit = txd;
                if (!sp_bit && b == 8'h00) begin
                    got = BRK_TOKEN;
                    while (!txd) @(negedge clk);
                end else begin
                    got = {1'b0, b};
                    check(st_bit == 1'b0 && sp_bit == 1'b1, "R2 framing",
                          int'({st_bit, sp_bit}), 1);
                end
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected item", int'(got), 0);
                end else begin
                    exp = sb.pop_front();
                    check(got == exp, "R2/R5 scoreboard order", int'(got), int'(exp));
                end
            end
            prev = txd;
        end
    end

    initial begin
        int hi;
        idle_clks(3);
        rst_n = 1'b1;
        idle_clks(2);
        // R1: reset state
        check(txd == 1'b1, "R1 txd", int'(txd), 1);
        check(fifo_empty && tx_empty, "R1 empty flags", int'({fifo_empty, tx_empty}), 3);
        check(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
        put_byte(8'h11, 1'b0);
        idle_clks(3 * BIT_CLKS);
        check(txd == 1'b1 && !fifo_empty, "R1 disabled after reset",
              int'({txd, fifo_empty}), 2);
        put_cmd(2'b00, 4'b0011);  // reset drops 0x11

        // R2: several patterns
        put_cmd(2'b01, 4'b0000);
        put_byte(8'h55, 1'b1);
        put_byte(8'hA3, 1'b1);
        put_byte(8'h00, 1'b1);
        put_byte(8'hFF, 1'b1);
        put_byte(8'h80, 1'b1);
        wait_drain();
        check(sb.size() == 0 && tx_empty, "R2 all frames sent", sb.size(), 0);

        // R11: byte in flight with empty queue
        put_byte(8'h6E, 1'b1);
        idle_clks(BIT_CLKS);
        check(fifo_empty == 1'b1 && tx_empty == 1'b0, "R11 shifting flags",
              int'({fifo_empty, tx_empty}), 2);
        wait_drain();

        // R3: disabled holds bytes
        put_cmd(2'b10, 4'b0000);
        put_byte(8'h3A, 1'b0);
        idle_clks(3 * BIT_CLKS);
        check(txd == 1'b1 && fifo_empty == 1'b0 && tx_empty == 1'b0, "R3 held while disabled",
              int'({txd, fifo_empty, tx_empty}), 4);
        sb.push_back({1'b0, 8'h3A});
        put_cmd(2'b01, 4'b0000);
        wait_drain();
        check(sb.size() == 0, "R3 sent after enable", sb.size(), 0);

        // R10: overrun
        put_cmd(2'b10, 4'b0000);
        for (int i = 0; i < 8; i++) begin
            put_byte(8'(8'hC0 + i), 1'b1);
            check(overrun == 1'b0, "R10 no overrun below full", int'(overrun), 0);
        end
        put_byte(8'hEE, 1'b0);
        check(overrun == 1'b1, "R10 overrun pulse", int'(overrun), 1);
        idle_clks(1);
        check(overrun == 1'b0, "R10 overrun one cycle", int'(overrun), 0);
        put_cmd(2'b01, 4'b0000);
        wait_drain();
        check(sb.size() == 0, "R10 eight kept in order", sb.size(), 0);

        // R4 + R7: break from idle, byte queued behind it
        sb.push_back(BRK_TOKEN);
        put_cmd(2'b00, 4'b0110);
        idle_clks(2);
        check(txd == 1'b0, "R4 break starts from idle", int'(txd), 0);
        put_byte(8'h3C, 1'b1);
        idle_clks(12 * BIT_CLKS);
        check(txd == 1'b0, "R4 break held", int'(txd), 0);
        put_cmd(2'b00, 4'b0111);
        check(txd == 1'b1, "R7 stop break marks at once", int'(txd), 1);
        hi = 1;
        while (txd) begin
            @(negedge clk);
            if (txd) hi++;
        end
        check(hi >= 60, "R7 marking before next byte", hi, 60);
        wait_drain();

        // R5: break waits for bytes, including one written in the command cycle
        put_byte(8'h12, 1'b1);
        put_byte(8'h34, 1'b1);
        put_both(2'b00, 4'b0110, 8'h56, 1'b1);
        idle_clks(100);
        put_byte(8'h78, 1'b1);
        sb.push_back(BRK_TOKEN);
        while (sb.size() > 1) @(negedge clk);
        idle_clks(3 * BIT_CLKS);
        check(txd == 1'b0, "R5 break after drain", int'(txd), 0);
        idle_clks(12 * BIT_CLKS);
        put_cmd(2'b00, 4'b0111);
        wait_drain();
        check(sb.size() == 0 && txd == 1'b1, "R5 order byte-then-break", sb.size(), 0);

        // R9: reset mid-byte with a same-cycle write
        mon_on = 1'b0;
        put_byte(8'h01, 1'b0);
        put_byte(8'h02, 1'b0);
        idle_clks(100);
        put_both(2'b00, 4'b0011, 8'h03, 1'b0);
        check(txd == 1'b1 && fifo_empty && tx_empty, "R9 reset clears",
              int'({txd, fifo_empty, tx_empty}), 7);
        idle_clks(3 * BIT_CLKS);
        check(txd == 1'b1, "R9 reset disables", int'(txd), 1);
        put_cmd(2'b01, 4'b0000);
        idle_clks(3 * BIT_CLKS);
        check(txd == 1'b1 && fifo_empty, "R9 same-cycle write dropped",
              int'({txd, fifo_empty}), 3);
        put_cmd(2'b10, 4'b0000);
        mon_on = 1'b1;

        // R8: conflicting writes ignored
        put_byte(8'h81, 1'b0);
        put_cmd(2'b01, 4'b0011);
        check(fifo_empty == 1'b0, "R8 reset part ignored", int'(fifo_empty), 0);
        idle_clks(3 * BIT_CLKS);
        check(txd == 1'b1, "R8 enable part ignored", int'(txd), 1);
        put_cmd(2'b11, 4'b0000);
        idle_clks(3 * BIT_CLKS);
        check(txd == 1'b1, "R8 illegal control ignored", int'(txd), 1);

        // R6: start break while disabled ignored
        put_cmd(2'b00, 4'b0110);
        sb.push_back({1'b0, 8'h81});
        put_cmd(2'b01, 4'b0000);
        wait_drain();
        idle_clks(6 * BIT_CLKS);
        check(txd == 1'b1 && sb.size() == 0, "R6 no break when disabled",
              int'(txd), 1);

        finish_run();
    end
endmodule